// File: doc/BRIEF.md
# Return-to-Zero / Transition Handshake Bridge

This block joins channels that use two different handshake conventions, and it carries a data word across in each direction. In the first direction, a sender uses the level-based return-to-zero protocol: it raises a request with valid data and later lowers it. The bridge passes each such transfer to a receiver that uses transition signalling, where every change of request is one transfer and every change of acknowledge completes it. The second direction does the reverse. A transition-signalling sender is converted into a return-to-zero request/acknowledge cycle toward a level-based receiver.

Both paths are push channels. The sender always starts a transfer and the receiver answers it. The bridge is modelled synchronously. Each incoming handshake wire is registered once, and events are found by comparing levels and parities. Synchronizer chains are not part of this block. Each direction latches its data word when it accepts a request. It then holds that word on its output until the far side has acknowledged.

Top module: `phase_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, fi_ack, to_req, ti_ack and fo_req are 0, and to_dat and fo_dat are 0. The transition parity bits are to_req and ti_ack.
- R2: Each rising edge of fi_req produces exactly one change of to_req. to_dat then carries the fi_dat value present while fi_req is high. The word is latched, so later changes of fi_dat do not reach to_dat.
- R3: fi_ack rises only after to_ack has changed to equal to_req. It falls only after fi_req has been seen low. No new transfer is taken on this side until fi_ack has returned to 0.
- R4: While to_req differs from to_ack, to_dat does not change.
- R5: Each change of ti_req produces exactly one high period of fo_req. While fo_req is high, fo_dat carries the ti_dat value present when ti_req changed.
- R6: fo_req falls only after fo_ack has been seen high. ti_ack changes only after fo_req is low and fo_ack has been seen low again. It then changes to equal ti_req.
- R7: fo_dat does not change while fo_req is high.
- R8: Across a long run with varying sender and receiver delays, neither direction loses, duplicates or reorders a word.
- R9: A request event applied between clock edges shows at the output at the second rising edge that follows. This applies to a fi_req rise, a to_ack change, a ti_req change and either edge of fo_ack. One edge is spent sampling the input and one updating the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fi_req | input | 1 | Return-to-zero request from the level-based sender |
| fi_ack | output | 1 | Return-to-zero acknowledge to the level-based sender |
| fi_dat | input | DW | Data from the level-based sender |
| to_req | output | 1 | Transition request to the transition receiver |
| to_ack | input | 1 | Transition acknowledge from the transition receiver |
| to_dat | output | DW | Data to the transition receiver |
| ti_req | input | 1 | Transition request from the transition sender |
| ti_ack | output | 1 | Transition acknowledge to the transition sender |
| ti_dat | input | DW | Data from the transition sender |
| fo_req | output | 1 | Return-to-zero request to the level-based receiver |
| fo_ack | input | 1 | Return-to-zero acknowledge from the level-based receiver |
| fo_dat | output | DW | Data to the level-based receiver |

## Verification
The assertions assume that all four partners keep to their protocol. A level-based sender does not raise fi_req again until fi_ack is low. A transition sender does not change ti_req a second time before ti_ack matches it. Receivers answer only a pending request, and only once. The bench tasks enforce this by construction. Each sender waits on the bridge's acknowledge before its next event, and each responder waits for a pending request before it acknowledges. Only the delays between these steps are varied.

// File: rtl/phase_bridge_pkg.sv
package phase_bridge_pkg;

  // return-to-zero in, transition out
  typedef enum logic [1:0] {
    RZ_IDLE = 2'd0,
    RZ_WAIT = 2'd1,
    RZ_HOLD = 2'd2
  } rz_in_state_e;

  // transition in, return-to-zero out
  typedef enum logic [1:0] {
    TR_IDLE  = 2'd0,
    TR_RAISE = 2'd1,
    TR_DROP  = 2'd2
  } tr_in_state_e;

endpackage

// File: rtl/hs_sample.sv
module hs_sample #(
  parameter int unsigned NB = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] d,
  output logic [NB-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/rz_to_tr.sv
module rz_to_tr
  import phase_bridge_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rz_req,
  output logic          rz_ack,
  input  logic [DW-1:0] rz_dat,
  output logic          tr_req,
  input  logic          tr_ack,
  output logic [DW-1:0] tr_dat
);

  logic         req_s, ack_s;
  rz_in_state_e st_q, st_d;
  logic         par_q, par_d;
  logic         ack_q, ack_d;
  logic         dat_en;
  logic [DW-1:0] dat_q;

  hs_sample #(.NB(2)) u_samp (
    .clk(clk), .rst_n(rst_n),
    .d({rz_req, tr_ack}), .q({req_s, ack_s})
  );

  always_comb begin
    st_d   = st_q;
    par_d  = par_q;
    ack_d  = ack_q;
    dat_en = 1'b0;
    case (st_q)
      RZ_IDLE: if (req_s) begin
        dat_en = 1'b1;
        par_d  = ~par_q;
        st_d   = RZ_WAIT;
      end
      RZ_WAIT: if (ack_s == par_q) begin
        ack_d = 1'b1;
        st_d  = RZ_HOLD;
      end
      RZ_HOLD: if (!req_s) begin
        ack_d = 1'b0;
        st_d  = RZ_IDLE;
      end
      default: st_d = RZ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RZ_IDLE;
      par_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      par_q <= par_d;
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= rz_dat;
  end

  assign rz_ack = ack_q;
  assign tr_req = par_q;
  assign tr_dat = dat_q;

endmodule

// File: rtl/tr_to_rz.sv
module tr_to_rz
  import phase_bridge_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tr_req,
  output logic          tr_ack,
  input  logic [DW-1:0] tr_dat,
  output logic          rz_req,
  input  logic          rz_ack,
  output logic [DW-1:0] rz_dat
);

  logic         req_s, ack_s;
  tr_in_state_e st_q, st_d;
  logic         par_q, par_d;
  logic         req_q, req_d;
  logic         dat_en;
  logic [DW-1:0] dat_q;

  hs_sample #(.NB(2)) u_samp (
    .clk(clk), .rst_n(rst_n),
    .d({tr_req, rz_ack}), .q({req_s, ack_s})
  );

  always_comb begin
    st_d   = st_q;
    par_d  = par_q;
    req_d  = req_q;
    dat_en = 1'b0;
    case (st_q)
      TR_IDLE: if (req_s != par_q) begin
        dat_en = 1'b1;
        req_d  = 1'b1;
        st_d   = TR_RAISE;
      end
      TR_RAISE: if (ack_s) begin
        req_d = 1'b0;
        st_d  = TR_DROP;
      end
      TR_DROP: if (!ack_s) begin
        par_d = ~par_q;
        st_d  = TR_IDLE;
      end
      default: st_d = TR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TR_IDLE;
      par_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      par_q <= par_d;
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= tr_dat;
  end

  assign tr_ack = par_q;
  assign rz_req = req_q;
  assign rz_dat = dat_q;

endmodule

// File: rtl/phase_bridge.sv
module phase_bridge #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fi_req,
  output logic          fi_ack,
  input  logic [DW-1:0] fi_dat,
  output logic          to_req,
  input  logic          to_ack,
  output logic [DW-1:0] to_dat,
  input  logic          ti_req,
  output logic          ti_ack,
  input  logic [DW-1:0] ti_dat,
  output logic          fo_req,
  input  logic          fo_ack,
  output logic [DW-1:0] fo_dat
);

  rz_to_tr #(.DW(DW)) u_rz2tr (
    .clk(clk), .rst_n(rst_n),
    .rz_req(fi_req), .rz_ack(fi_ack), .rz_dat(fi_dat),
    .tr_req(to_req), .tr_ack(to_ack), .tr_dat(to_dat)
  );

  tr_to_rz #(.DW(DW)) u_tr2rz (
    .clk(clk), .rst_n(rst_n),
    .tr_req(ti_req), .tr_ack(ti_ack), .tr_dat(ti_dat),
    .rz_req(fo_req), .rz_ack(fo_ack), .rz_dat(fo_dat)
  );

endmodule

// File: rtl/phase_bridge_chk.sv
module phase_bridge_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fi_req,
  input logic          fi_ack,
  input logic [DW-1:0] fi_dat,
  input logic          to_req,
  input logic          to_ack,
  input logic [DW-1:0] to_dat,
  input logic          ti_req,
  input logic          ti_ack,
  input logic [DW-1:0] ti_dat,
  input logic          fo_req,
  input logic          fo_ack,
  input logic [DW-1:0] fo_dat
);

  a_r2_one_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (to_req != $past(to_req)) |-> (!fi_ack && $past(fi_req) && ($past(to_req) == $past(to_ack))));

  a_r3_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fi_ack) |-> (to_req == to_ack));

  a_r3_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fi_ack) |-> !$past(fi_req));

  a_r4_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (to_req != to_ack) |=> $stable(to_dat));

  a_r5_fo_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fo_req) |-> ($past(ti_req) != ti_ack));

  a_r6_fo_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fo_req) |-> $past(fo_ack));

  a_r6_ti_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ti_ack != $past(ti_ack)) |-> (!fo_req && !$past(fo_ack)));

  a_r7_fo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fo_req |=> $stable(fo_dat));

endmodule

bind phase_bridge phase_bridge_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_phase_bridge.sv
module test_phase_bridge;

  localparam int DW = 8;
  localparam int N  = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fi_req = 1'b0, to_ack = 1'b0, ti_req = 1'b0, fo_ack = 1'b0;
  logic [DW-1:0] fi_dat = '0, ti_dat = '0;
  logic fi_ack, to_req, ti_ack, fo_req;
  logic [DW-1:0] to_dat, fo_dat;

  int checks = 0, failures = 0, cyc = 0;
  int ra_cnt = 0, rb_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  phase_bridge #(.DW(DW)) i_phase_bridge (.*);

  function automatic logic [DW-1:0] pat_a(int i);
    return DW'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [DW-1:0] pat_b(int i);
    return DW'((i * 53 + 7) & 255);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL R8 watchdog expired actual=%0d expected<=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic send_a();
    for (int i = 0; i < N; i++) begin
      repeat ($urandom_range(3, 0)) @(negedge clk);
      fi_dat = pat_a(i);
      fi_req = 1'b1;
      while (fi_ack !== 1'b1) @(negedge clk);
      check("R3 ack only after transition ack", 32'(ra_cnt > i), 1);
      repeat ($urandom_range(2, 0)) @(negedge clk);
      fi_req = 1'b0;
      fi_dat = ~pat_a(i);
      while (fi_ack !== 1'b0) @(negedge clk);
    end
  endtask

  task automatic recv_a();
    for (int j = 0; j < N; j++) begin
      bit ok;
      logic [DW-1:0] seen;
      while (to_req === to_ack) @(negedge clk);
      seen = to_dat;
      check("R2 R8 word order", 32'(seen), 32'(pat_a(j)));
      ok = 1;
      repeat ($urandom_range(3, 0)) begin
        @(negedge clk);
        if (to_dat !== seen || fi_ack !== 1'b0) ok = 0;
      end
      check("R4 to_dat held, fi_ack low while pending", 32'(ok), 1);
      ra_cnt = j + 1;
      to_ack = ~to_ack;
      @(negedge clk);
    end
  endtask

  task automatic send_b();
    for (int i = 0; i < N; i++) begin
      repeat ($urandom_range(3, 0)) @(negedge clk);
      ti_dat = pat_b(i);
      ti_req = ~ti_req;
      while (ti_ack !== ti_req) @(negedge clk);
      check("R6 ti_ack after full cycle", 32'(rb_cnt > i), 1);
      ti_dat = ~pat_b(i);
    end
  endtask

  task automatic recv_b();
    for (int j = 0; j < N; j++) begin
      bit ok;
      logic hold;
      logic [DW-1:0] seen;
      while (fo_req !== 1'b1) @(negedge clk);
      seen = fo_dat;
      hold = ti_ack;
      check("R5 R8 word order", 32'(seen), 32'(pat_b(j)));
      ok = 1;
      repeat ($urandom_range(3, 0)) begin
        @(negedge clk);
        if (fo_dat !== seen || fo_req !== 1'b1) ok = 0;
      end
      check("R7 fo_dat held while fo_req high", 32'(ok), 1);
      fo_ack = 1'b1;
      while (fo_req !== 1'b0) @(negedge clk);
      ok = 1;
      repeat ($urandom_range(3, 0)) begin
        @(negedge clk);
        if (ti_ack !== hold) ok = 0;
      end
      check("R6 ti_ack waits for fo_ack low", 32'(ok), 1);
      rb_cnt = j + 1;
      fo_ack = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset fi_ack", 32'(fi_ack), 0);
    check("R1 reset to_req", 32'(to_req), 0);
    check("R1 reset ti_ack", 32'(ti_ack), 0);
    check("R1 reset fo_req", 32'(fo_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release outputs", 32'({fi_ack, to_req, ti_ack, fo_req}), 0);
    check("R1 after release data", 32'({to_dat, fo_dat}), 0);

    // directed: return-to-zero in, transition out
    fi_dat = 8'hA5; fi_req = 1'b1;
    @(negedge clk); check("R9 to_req not yet", 32'(to_req), 0);
    @(negedge clk); check("R9 to_req toggled", 32'(to_req), 1);
    check("R2 latched word", 32'(to_dat), 32'h A5);
    fi_dat = 8'h00;
    to_ack = 1'b1;
    @(negedge clk); check("R9 fi_ack not yet", 32'(fi_ack), 0);
    check("R2 latch ignores fi_dat change", 32'(to_dat), 32'h A5);
    @(negedge clk); check("R3 R9 fi_ack raised", 32'(fi_ack), 1);
    repeat (2) @(negedge clk); check("R3 fi_ack held while fi_req high", 32'(fi_ack), 1);
    fi_req = 1'b0;
    @(negedge clk); check("R9 fi_ack still high", 32'(fi_ack), 1);
    @(negedge clk); check("R3 fi_ack lowered", 32'(fi_ack), 0);
    check("R2 single toggle", 32'(to_req), 1);

    // directed: transition in, return-to-zero out
    ti_dat = 8'h3C; ti_req = 1'b1;
    @(negedge clk); check("R9 fo_req not yet", 32'(fo_req), 0);
    @(negedge clk); check("R5 R9 fo_req raised", 32'(fo_req), 1);
    check("R5 fo_dat word", 32'(fo_dat), 32'h3C);
    ti_dat = 8'h00;
    repeat (2) @(negedge clk); check("R6 fo_req held without ack", 32'(fo_req), 1);
    fo_ack = 1'b1;
    @(negedge clk); check("R9 fo_req still high", 32'(fo_req), 1);
    @(negedge clk); check("R6 fo_req dropped", 32'(fo_req), 0);
    check("R6 ti_ack waits", 32'(ti_ack), 0);
    fo_ack = 1'b0;
    @(negedge clk); check("R9 ti_ack not yet", 32'(ti_ack), 0);
    @(negedge clk); check("R6 ti_ack toggled", 32'(ti_ack), 1);
    repeat (3) @(negedge clk); check("R5 single pulse", 32'(fo_req), 0);

    // long run with varying delays in both directions
    fork
      send_a();
      recv_a();
      send_b();
      recv_b();
    join

    repeat (10) @(negedge clk);
    check("R8 all words through A", 32'(ra_cnt), 32'(N));
    check("R8 all words through B", 32'(rb_cnt), 32'(N));
    check("R8 no extra toggle on to_req", 32'(to_req), 32'(to_ack));
    check("R8 no extra fo_req", 32'(fo_req), 0);
    check("R8 ti_ack matches ti_req", 32'(ti_ack), 32'(ti_req));
    finish_run();
  end

endmodule